// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block sits beside the conversion sequencer of an analog-to-digital converter. It watches the stream of conversion results against a small number of programmable window comparators. Each comparator set holds a lower bound, an upper bound and a channel-select field. Because of that field, a set guards exactly one input channel at a time. To guard a different channel with the same window, software rewrites the select field of that set.

When a result for a selected channel arrives, the set compares it to its window. A violation raises a low or a high pending flag in a status register. Pending flags are sticky and are cleared by writing 1 to them. A mask register decides, flag by flag, whether a pending flag drives the single registered interrupt line. An upper bound programmed below the lower bound resolves as follows: a result under the lower bound reports low, and every other result above the upper bound reports high.

Top module: `adc_wd_top`

## Requirements
- R1: After a synchronous reset, every register reads as zero and `irq` is low.
- R2: The window register of set k is at address k (k = 0..3). It holds the lower bound in bits [11:0] and the upper bound in bits [27:16]. The select register of set k is at address 4+k, with the channel in bits [5:0]. Unused bits read as 0. Status is at address 8 and mask at address 9. In both, bit 2k is the low flag of set k and bit 2k+1 is its high flag.
- R3: A set compares a result only in a cycle where `res_vld` is high and `res_ch` equals that set's channel. Any other result leaves its flags unchanged.
- R4: For a set with a normal window, a result strictly below the lower bound sets the low flag. A result equal to the lower bound does not set it.
- R5: A result strictly above the upper bound sets the high flag. A result inside the window, including either bound, sets neither flag.
- R6: When the upper bound is below the lower bound, a result below the lower bound sets only the low flag. Any result at or above the lower bound sets only the high flag.
- R7: Pending flags stay set until cleared. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: If a flag is set by a result and cleared by a status write in the same cycle, the flag ends up set.
- R9: `irq` is high one cycle after any status bit and its mask bit are both 1. A pending flag whose mask bit is 0 does not raise `irq`.
- R10: Several sets may select the same channel. Each judges the same result against its own window, independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| res_vld | input | 1 | Conversion result valid strobe |
| res_ch | input | 6 | Channel number of the result |
| res_data | input | 12 | Conversion result value |
| irq | output | 1 | Registered interrupt request |

## Verification
The case that is hardest to reach from the ports is a status clear that lands in the same clock as a new violation of the same flag. The bench drives the result strobe and a status write together in one cycle to reach it. It also covers the inverted window, where one result can raise the high flag of one set and the low flag of another set on the same channel. Directed cases hit each bound exactly. A seeded random phase then mixes window rewrites (some of them inverted), channel changes, clears and mask writes. Results are biased to land near the programmed bounds.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;
    localparam int NSET_D = 4;
    localparam int DW_D   = 12;
    localparam int CHW_D  = 6;
    localparam int BW_D   = 32;
    localparam int HI_LSB = 16;

    typedef struct packed {
        logic high;
        logic low;
    } flag_pair_t;

    function automatic int flag_idx(input int set, input bit is_high);
        return 2 * set + (is_high ? 1 : 0);
    endfunction
endpackage

// File: rtl/adc_wd_regs.sv
module adc_wd_regs
    import adc_wd_pkg::*;
#(
    parameter int NSET = NSET_D,
    parameter int DW   = DW_D,
    parameter int CHW  = CHW_D,
    parameter int BW   = BW_D,
    parameter int AW   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [BW-1:0]                 wdata,
    output logic [NSET-1:0][DW-1:0]       lo_o,
    output logic [NSET-1:0][DW-1:0]       hi_o,
    output logic [NSET-1:0][CHW-1:0]      sel_o
);
    for (genvar k = 0; k < NSET; k++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_o[k]  <= '0;
                hi_o[k]  <= '0;
                sel_o[k] <= '0;
            end else if (we) begin
                if (addr == AW'(k)) begin
                    lo_o[k] <= wdata[DW-1:0];
                    hi_o[k] <= wdata[HI_LSB +: DW];
                end
                if (addr == AW'(NSET + k))
                    sel_o[k] <= wdata[CHW-1:0];
            end
        end
    end
endmodule

// File: rtl/adc_wd_window.sv
module adc_wd_window
    import adc_wd_pkg::*;
#(
    parameter int DW  = DW_D,
    parameter int CHW = CHW_D
) (
    input  logic           vld,
    input  logic [CHW-1:0] ch,
    input  logic [DW-1:0]  data,
    input  logic [CHW-1:0] sel,
    input  logic [DW-1:0]  lo,
    input  logic [DW-1:0]  hi,
    output flag_pair_t     ev
);
    logic hit, below;
    always_comb begin
        hit     = vld && (ch == sel);
        below   = data < lo;
        ev.low  = hit && below;
        ev.high = hit && !below && (data > hi);
    end
endmodule

// File: rtl/adc_wd_flags.sv
module adc_wd_flags #(
    parameter int FLW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [FLW-1:0] set_ev,
    input  logic           we_stat,
    input  logic           we_mask,
    input  logic [FLW-1:0] wdata,
    output logic [FLW-1:0] status_o,
    output logic [FLW-1:0] mask_o,
    output logic           irq_o
);
    logic [FLW-1:0] clr;

    always_comb clr = we_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            mask_o   <= '0;
            irq_o    <= 1'b0;
        end else begin
            status_o <= (status_o & ~clr) | set_ev;
            if (we_mask) mask_o <= wdata;
            irq_o    <= |(status_o & mask_o);
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (set_ev != '0) |=> ((status_o & $past(set_ev)) == $past(set_ev)));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (we_stat && ((wdata & ~set_ev) != '0)) |=> ((status_o & $past(wdata & ~set_ev)) == '0));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (status_o != '0) |=> ((status_o & $past(status_o & ~clr)) == $past(status_o & ~clr)));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(status_o & mask_o)));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> !$past(|(status_o & mask_o)));
endmodule

// File: rtl/adc_wd_top.sv
module adc_wd_top
    import adc_wd_pkg::*;
#(
    parameter int NSET = NSET_D,
    parameter int DW   = DW_D,
    parameter int CHW  = CHW_D,
    parameter int BW   = BW_D,
    parameter int AW   = $clog2(2 * NSET + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [BW-1:0]  bus_wdata,
    output logic [BW-1:0]  bus_rdata,
    input  logic           res_vld,
    input  logic [CHW-1:0] res_ch,
    input  logic [DW-1:0]  res_data,
    output logic           irq
);
    localparam int FLW    = 2 * NSET;
    localparam int STAT_A = 2 * NSET;
    localparam int MASK_A = 2 * NSET + 1;

    logic [NSET-1:0][DW-1:0]  lo_q, hi_q;
    logic [NSET-1:0][CHW-1:0] sel_q;
    flag_pair_t [NSET-1:0]    ev;
    logic [FLW-1:0]           set_ev, status_q, mask_q;

    adc_wd_regs #(.NSET(NSET), .DW(DW), .CHW(CHW), .BW(BW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .lo_o(lo_q), .hi_o(hi_q), .sel_o(sel_q)
    );

    for (genvar k = 0; k < NSET; k++) begin : g_win
        adc_wd_window #(.DW(DW), .CHW(CHW)) u_win (
            .vld(res_vld), .ch(res_ch), .data(res_data),
            .sel(sel_q[k]), .lo(lo_q[k]), .hi(hi_q[k]), .ev(ev[k])
        );
        assign set_ev[2*k]   = ev[k].low;
        assign set_ev[2*k+1] = ev[k].high;

        assert_low_below_R4: assert property (@(posedge clk) disable iff (rst)
            set_ev[2*k] |-> (res_data < lo_q[k]));
        assert_high_above_R5: assert property (@(posedge clk) disable iff (rst)
            set_ev[2*k+1] |-> ((res_data > hi_q[k]) && (res_data >= lo_q[k])));
    end

    adc_wd_flags #(.FLW(FLW)) u_flags (
        .clk(clk), .rst(rst), .set_ev(set_ev),
        .we_stat(bus_we && (bus_addr == AW'(STAT_A))),
        .we_mask(bus_we && (bus_addr == AW'(MASK_A))),
        .wdata(bus_wdata[FLW-1:0]),
        .status_o(status_q), .mask_o(mask_q), .irq_o(irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NSET; k++) begin
            if (bus_addr == AW'(k)) begin
                bus_rdata[DW-1:0]       = lo_q[k];
                bus_rdata[HI_LSB +: DW] = hi_q[k];
            end
            if (bus_addr == AW'(NSET + k))
                bus_rdata[CHW-1:0] = sel_q[k];
        end
        if (bus_addr == AW'(STAT_A)) bus_rdata[FLW-1:0] = status_q;
        if (bus_addr == AW'(MASK_A)) bus_rdata[FLW-1:0] = mask_q;
    end

    assert_strobe_only_R3: assert property (@(posedge clk) disable iff (rst)
        (set_ev != '0) |-> res_vld);
endmodule

// File: tb/adc_wd_top_bench.sv
module adc_wd_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic        clk = 0, rst = 1;
    logic        bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        res_vld = 0;
    logic [5:0]  res_ch = 0;
    logic [11:0] res_data = 0;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;

    logic [11:0] m_lo [NS];
    logic [11:0] m_hi [NS];
    logic [5:0]  m_sel[NS];
    logic [7:0]  m_st = 0, m_mk = 0;

    adc_wd_top u_adc_wd_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_vld(res_vld),
        .res_ch(res_ch), .res_data(res_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_ev(input logic [5:0] ch, input logic [11:0] d);
        logic [7:0] e = '0;
        for (int k = 0; k < NS; k++) begin
            if (m_sel[k] == ch) begin
                if (d < m_lo[k])      e[2*k]   = 1'b1;
                else if (d > m_hi[k]) e[2*k+1] = 1'b1;
            end
        end
        return e;
    endfunction

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        if (a < 4) begin m_lo[a[1:0]] = d[11:0]; m_hi[a[1:0]] = d[27:16]; end
        else if (a < 8) m_sel[a[1:0]] = d[5:0];
        else if (a == 8) m_st = m_st & ~d[7:0];
        else if (a == 9) m_mk = d[7:0];
        @(negedge clk);
    endtask

    task automatic strobe(input logic vld, input logic [5:0] ch, input logic [11:0] d,
                          input logic [7:0] clr, input string req);
        logic        irq_old;
        logic [31:0] st;
        irq_old = |(m_st & m_mk);
        res_vld = vld; res_ch = ch; res_data = d;
        if (clr != 0) begin bus_we = 1; bus_addr = 4'd8; bus_wdata = {24'd0, clr}; end
        @(negedge clk);
        res_vld = 0; bus_we = 0;
        m_st = (m_st & ~clr) | (vld ? expect_ev(ch, d) : 8'd0);
        rd(4'd8, st);
        chk(req, st, {24'd0, m_st});
        chk("R9 irq lags status", {31'd0, irq}, {31'd0, irq_old});
        @(negedge clk);
        chk("R9 irq after status", {31'd0, irq}, {31'd0, |(m_st & m_mk)});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int k = 0; k < NS; k++) begin m_lo[k] = 0; m_hi[k] = 0; m_sel[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        for (int a = 0; a < 10; a++) begin rd(4'(a), d); chk("R1 reset reg", d, 32'd0); end
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        // R2 field layout, unused bits zero
        wr(4'd0, 32'hF0C8_F064);
        rd(4'd0, d); chk("R2 window readback", d, 32'h00C8_0064);
        wr(4'd4, 32'hFFFF_FFC3);
        rd(4'd4, d); chk("R2 select readback", d, 32'h0000_0003);
        for (int k = 1; k < NS; k++) wr(4'(4 + k), 32'd40);
        // R3 wrong channel and no strobe
        strobe(1, 6'd5, 12'd10, 0, "R3 other channel");
        strobe(0, 6'd3, 12'd10, 0, "R3 no strobe");
        // R4 bound checks
        strobe(1, 6'd3, 12'd100, 0, "R4 equal lower");
        strobe(1, 6'd3, 12'd99, 0, "R4 below lower");
        // R7 write zero no effect, write one clears
        wr(4'd8, 32'd0);
        rd(4'd8, d); chk("R7 write zero keeps", d, 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd8, d); chk("R7 w1c", d, 32'h0);
        // R5
        strobe(1, 6'd3, 12'd200, 0, "R5 equal upper");
        strobe(1, 6'd3, 12'd150, 0, "R5 inside");
        strobe(1, 6'd3, 12'd201, 0, "R5 above upper");
        wr(4'd8, 32'hFF);
        // R6 and R10: set 1 inverted on same channel
        wr(4'd1, {4'd0, 12'd100, 4'd0, 12'd300});
        wr(4'd5, 32'd3);
        strobe(1, 6'd3, 12'd299, 0, "R6 R10 below inverted lower");
        wr(4'd8, 32'hFF);
        strobe(1, 6'd3, 12'd300, 0, "R6 at inverted lower");
        wr(4'd8, 32'hFF);
        strobe(1, 6'd3, 12'd150, 0, "R6 R10 between inverted bounds");
        strobe(1, 6'd3, 12'd50, 0, "R6 R10 low both");
        // R8 set wins over same-cycle clear; other bits clear
        strobe(1, 6'd3, 12'd50, 8'hFF, "R8 set wins");
        // R9 masking
        chk("R9 masked no irq", {31'd0, irq}, 32'd0);
        bus_we = 1; bus_addr = 4'd9; bus_wdata = 32'h1;
        @(negedge clk); bus_we = 0; m_mk = 8'h1;
        chk("R9 irq one cycle later not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        // random phase
        void'($urandom(32'd4242));
        for (int i = 0; i < 400; i++) begin
            int unsigned op = $urandom % 6;
            int unsigned k  = $urandom % NS;
            case (op)
                0: wr(4'(k), {4'd0, 12'($urandom), 4'd0, 12'($urandom)});
                1: wr(4'(4 + k), 32'($urandom % 3));
                2: wr(4'd8, 32'($urandom % 256));
                3: wr(4'd9, 32'($urandom % 256));
                default: begin
                    logic [11:0] base = ($urandom % 2) ? m_lo[k] : m_hi[k];
                    logic [11:0] dv = base + 12'($urandom % 5) - 12'd2;
                    logic [7:0]  cl = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
                    strobe(1, 6'($urandom % 3), dv, cl, "R4 R5 R6 R8 random");
                end
            endcase
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule